// File: doc/BRIEF.md
# Flywheel TRS Regenerator

This block sits in a 10-bit digital video word stream, one word per clock, and repairs its timing reference sequences. An internal flywheel counts samples per line and lines per frame. It locks to the end-of-active-video sequences it receives. Once it is locked, it can blank sync sequences that turn up where the flywheel does not expect them. It can also write freshly built start-of-active and end-of-active sequences at the expected positions, which corrects a damaged protection word.

Standard detection is done elsewhere and arrives as a two-bit code. The block latches the last valid code. It therefore keeps its line timing, and keeps inserting sync sequences, after the incoming signal goes away. A flywheel enable input switches all flywheel-based editing off and returns the flywheel to the unlocked state.

Top module: `trs_regen`

## Requirements
- R1: `dout` is cleared to 0 by reset. It carries `din` delayed by exactly four clocks, unchanged, for every word that no enabled edit touches.
- R2: A generated sequence is 3FF, 000, 000, then a protection word. In the protection word, bit 9 is 1, bit 8 is F, bit 7 is V and bit 6 is H. Bits 5..2 are V^H, F^H, F^V and F^V^H, and bits 1..0 are 0. H is 1 for end-of-active and 0 for start-of-active.
- R3: A received sequence counts as end-of-active when its fourth word has bit 6 set. The flywheel locks when a second end-of-active arrives exactly one line after the first. Before lock, and for a stream with no sync sequences, `dout` is a pure delay of `din`.
- R4: When `ins_en`, `fw_en` and lock are all high, the output is replaced at two places in each line. Line samples 0..3 become end-of-active and samples SAV..SAV+3 become start-of-active, where SAV = samples_per_line − active_samples − 4.
- R5: A sequence that already sits at an expected position is still overwritten, so a wrong protection word leaves the block corrected.
- R6: When `blk_en`, `fw_en` and lock are all high, a received sequence that starts at any sample other than 0 or SAV has its four words replaced by blanking levels. An even sample gets 200 and an odd sample gets 040. Insertion takes priority where the two overlap.
- R7: A received sequence that starts at sample 0 or SAV is never blanked, even if its protection word is wrong.
- R8: After the input loses its sync sequences, or `std_code` returns to 00, the flywheel keeps running with the latched standard. Insertion continues with the correct F and V values.
- R9: While `fw_en` is low, no word is blanked or inserted and the flywheel unlocks.
- R10: `std_code` 01 selects standard A and 10 selects standard B; 00 and 11 leave the latched standard unchanged. A change of the latched standard unlocks the flywheel, and the next lock uses the new line length and SAV.
- R11: Lines are numbered from 0. F = (line ≥ lines/2). V is 1 for line < VB and for lines/2 ≤ line < lines/2+VB. The line count is reset to 0 by a received end-of-active with F=0, V=1 that follows one with F=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 10 | Incoming video word |
| std_code | input | 2 | Detected standard: 01 A, 10 B, else none |
| fw_en | input | 1 | Flywheel enable |
| ins_en | input | 1 | Sync-sequence insertion enable |
| blk_en | input | 1 | Misplaced-sequence blanking enable |
| dout | output | 10 | Corrected word stream, four clocks behind `din` |

## Verification
The bench builds the block with tiny standards. Standard A has 16 samples per line, 6 lines, 8 active samples and VB=1. Standard B has 20 samples, 8 lines, 10 active samples and VB=2. A whole frame is then only 96 or 160 words, so every word of several frames can be compared against an arithmetically computed stream. The runs cover damaged protection words, misplaced sequences, signal loss, flywheel disable and a standard switch. All eight combinations of F, V and H are reached within a single frame.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int WORD_W = 10;
  localparam logic [WORD_W-1:0] SYNC_ONES  = 10'h3FF;
  localparam logic [WORD_W-1:0] SYNC_ZERO  = 10'h000;
  localparam logic [WORD_W-1:0] BLANK_EVEN = 10'h200;
  localparam logic [WORD_W-1:0] BLANK_ODD  = 10'h040;

  // Protection word: marker, F, V, H, four Hamming bits, two zeros
  function automatic logic [WORD_W-1:0] make_xyz(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction
endpackage

// File: rtl/trs_detect.sv
module trs_detect
  import trs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] oldest,
  output logic              trs_start,
  output logic              xyz_f,
  output logic              xyz_v,
  output logic              xyz_h
);
  localparam int DEPTH = 3;

  logic [WORD_W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  // Window: oldest word is the 3FF, din carries the protection word
  assign oldest    = pipe[DEPTH-1];
  assign trs_start = (pipe[2] == SYNC_ONES) && (pipe[1] == SYNC_ZERO) &&
                     (pipe[0] == SYNC_ZERO) && din[9];
  assign xyz_f = din[8];
  assign xyz_v = din[7];
  assign xyz_h = din[6];
endmodule

// File: rtl/trs_flywheel.sv
module trs_flywheel #(
  parameter int SPL_A   = 1716,
  parameter int SPL_B   = 1728,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int HW      = 11,
  parameter int LW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fw_en,
  input  logic [1:0]    std_code,
  input  logic          trs_start,
  input  logic          xyz_f,
  input  logic          xyz_v,
  input  logic          xyz_h,
  output logic [HW-1:0] hpos,
  output logic [LW-1:0] line,
  output logic          locked,
  output logic          std_b,
  output logic          std_valid
);
  localparam logic [HW-1:0] HMAX_A = HW'(SPL_A - 1);
  localparam logic [HW-1:0] HMAX_B = HW'(SPL_B - 1);
  localparam logic [LW-1:0] LMAX_A = LW'(LINES_A - 1);
  localparam logic [LW-1:0] LMAX_B = LW'(LINES_B - 1);

  logic [HW-1:0] hmax;
  logic [LW-1:0] lmax;
  logic code_ok, code_b, std_chg, eav_det, seen, prev_f;

  assign hmax    = std_b ? HMAX_B : HMAX_A;
  assign lmax    = std_b ? LMAX_B : LMAX_A;
  assign code_ok = (std_code == 2'b01) || (std_code == 2'b10);
  assign code_b  = (std_code == 2'b10);
  assign std_chg = code_ok && (!std_valid || (code_b != std_b));
  assign eav_det = trs_start && xyz_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      std_valid <= 1'b0;
      std_b     <= 1'b0;
    end else if (std_chg) begin
      std_valid <= 1'b1;
      std_b     <= code_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !fw_en) begin
      hpos <= '0; line <= '0; locked <= 1'b0; seen <= 1'b0; prev_f <= 1'b0;
    end else if (std_chg) begin
      hpos <= '0; line <= '0; locked <= 1'b0; seen <= 1'b0;
    end else begin
      if (eav_det && !locked) begin
        hpos <= HW'(1);
        seen <= 1'b1;
        if (seen && (hpos == '0) && std_valid) locked <= 1'b1;
      end else if (hpos == hmax) begin
        hpos <= '0;
        line <= (line == lmax) ? '0 : line + LW'(1);
      end else begin
        hpos <= hpos + HW'(1);
      end
      if (eav_det && (!locked || (hpos == '0))) begin
        prev_f <= xyz_f;
        if (prev_f && !xyz_f && xyz_v) line <= '0;
      end
    end
  end

  a_r9_fw_off_unlocks: assert property (@(posedge clk) disable iff (rst) !fw_en |=> !locked);
  a_r10_lock_needs_std: assert property (@(posedge clk) disable iff (rst) locked |-> std_valid);
  a_r3_hpos_in_line: assert property (@(posedge clk) disable iff (rst) hpos <= hmax);
  a_r3_lock_on_eav: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(trs_start && xyz_h));
endmodule

// File: rtl/trs_editor.sv
module trs_editor
  import trs_pkg::*;
#(
  parameter int HW      = 11,
  parameter int LW      = 10,
  parameter int SAVP_A  = 272,
  parameter int SAVP_B  = 284,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int VB_A    = 19,
  parameter int VB_B    = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic              trs_start,
  input  logic [HW-1:0]     hpos,
  input  logic [LW-1:0]     line,
  input  logic              std_b,
  input  logic              ins_act,
  input  logic              blk_act,
  output logic [WORD_W-1:0] dout
);
  localparam logic [HW-1:0] SAV_A  = HW'(SAVP_A);
  localparam logic [HW-1:0] SAV_B  = HW'(SAVP_B);
  localparam logic [LW-1:0] HALF_A = LW'(LINES_A / 2);
  localparam logic [LW-1:0] HALF_B = LW'(LINES_B / 2);
  localparam logic [LW-1:0] VEND_A = LW'(VB_A);
  localparam logic [LW-1:0] VEND_B = LW'(VB_B);
  localparam logic [LW-1:0] V2_A   = LW'(LINES_A / 2 + VB_A);
  localparam logic [LW-1:0] V2_B   = LW'(LINES_B / 2 + VB_B);

  logic [HW-1:0] savp;
  logic [1:0]    idx, bcnt;
  logic f, v, in_eav, in_sav, in_win, mis_now, blk_sel;
  logic [WORD_W-1:0] gen, nxt;

  assign savp   = std_b ? SAV_B : SAV_A;
  assign f      = line >= (std_b ? HALF_B : HALF_A);
  assign v      = (line < (std_b ? VEND_B : VEND_A)) || (f && (line < (std_b ? V2_B : V2_A)));
  assign in_eav = hpos < HW'(4);
  assign in_sav = (hpos >= savp) && (hpos < savp + HW'(4));
  assign in_win = in_eav || in_sav;
  assign idx    = in_eav ? hpos[1:0] : 2'(hpos - savp);

  always_comb begin
    case (idx)
      2'd0:    gen = SYNC_ONES;
      2'd3:    gen = make_xyz(f, v, in_eav);
      default: gen = SYNC_ZERO;
    endcase
  end

  assign mis_now = trs_start && (hpos != '0) && (hpos != savp);
  assign blk_sel = blk_act && (mis_now || (bcnt != 2'd0));

  always_comb begin
    if (ins_act && in_win)  nxt = gen;
    else if (blk_sel)       nxt = hpos[0] ? BLANK_ODD : BLANK_EVEN;
    else                    nxt = word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt <= 2'd0;
      dout <= '0;
    end else begin
      bcnt <= mis_now ? 2'd3 : ((bcnt != 2'd0) ? bcnt - 2'd1 : 2'd0);
      dout <= nxt;
    end
  end

  a_r4_eav_head: assert property (@(posedge clk) disable iff (rst)
    ins_act && (hpos == '0) |=> dout == SYNC_ONES);
  a_r2_xyz_frame: assert property (@(posedge clk) disable iff (rst)
    ins_act && (hpos == HW'(3)) |=> dout[9] && (dout[1:0] == 2'b00));
  a_r6_blank_level: assert property (@(posedge clk) disable iff (rst)
    blk_act && mis_now && !(ins_act && in_win) |=> (dout == BLANK_EVEN) || (dout == BLANK_ODD));
endmodule

// File: rtl/trs_regen.sv
module trs_regen #(
  parameter int SPL_A   = 1716,
  parameter int LINES_A = 525,
  parameter int ACT_A   = 1440,
  parameter int VB_A    = 19,
  parameter int SPL_B   = 1728,
  parameter int LINES_B = 625,
  parameter int ACT_B   = 1440,
  parameter int VB_B    = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [9:0] din,
  input  logic [1:0] std_code,
  input  logic       fw_en,
  input  logic       ins_en,
  input  logic       blk_en,
  output logic [9:0] dout
);
  localparam int SPL_MAX = (SPL_A > SPL_B) ? SPL_A : SPL_B;
  localparam int LN_MAX  = (LINES_A > LINES_B) ? LINES_A : LINES_B;
  localparam int HW      = $clog2(SPL_MAX);
  localparam int LW      = $clog2(LN_MAX);
  localparam int SAVP_A  = SPL_A - ACT_A - 4;
  localparam int SAVP_B  = SPL_B - ACT_B - 4;

  logic [9:0]    oldest;
  logic          trs_start, xf, xv, xh, locked, std_b, std_valid;
  logic [HW-1:0] hpos;
  logic [LW-1:0] line;
  logic          ins_act, blk_act;
  logic [2:0]    warm;

  trs_detect u_det (
    .clk(clk), .rst(rst), .din(din), .oldest(oldest), .trs_start(trs_start),
    .xyz_f(xf), .xyz_v(xv), .xyz_h(xh)
  );

  trs_flywheel #(
    .SPL_A(SPL_A), .SPL_B(SPL_B), .LINES_A(LINES_A), .LINES_B(LINES_B), .HW(HW), .LW(LW)
  ) u_fw (
    .clk(clk), .rst(rst), .fw_en(fw_en), .std_code(std_code), .trs_start(trs_start),
    .xyz_f(xf), .xyz_v(xv), .xyz_h(xh), .hpos(hpos), .line(line), .locked(locked),
    .std_b(std_b), .std_valid(std_valid)
  );

  assign ins_act = fw_en && locked && ins_en;
  assign blk_act = fw_en && locked && blk_en;

  trs_editor #(
    .HW(HW), .LW(LW), .SAVP_A(SAVP_A), .SAVP_B(SAVP_B), .LINES_A(LINES_A),
    .LINES_B(LINES_B), .VB_A(VB_A), .VB_B(VB_B)
  ) u_ed (
    .clk(clk), .rst(rst), .word(oldest), .trs_start(trs_start), .hpos(hpos), .line(line),
    .std_b(std_b), .ins_act(ins_act), .blk_act(blk_act), .dout(dout)
  );

  always_ff @(posedge clk) begin
    if (rst)              warm <= 3'd0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  a_r1_pure_delay: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd6) && !ins_en && !blk_en |=> dout == $past(din, 4));
  a_r9_no_edit_when_off: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd6) && !fw_en |=> dout == $past(din, 4));
endmodule

// File: tb/sim_trs_regen.sv
module sim_trs_regen;
  localparam int SPLA = 16, LNA = 6, ACA = 8, VBA = 1;
  localparam int SPLB = 20, LNB = 8, ACB = 10, VBB = 2;

  logic clk = 1'b0, rst = 1'b1, fw_en = 1'b0, ins_en = 1'b0, blk_en = 1'b0;
  logic [9:0] din = '0;
  logic [1:0] std_code = 2'b00;
  logic [9:0] dout;

  int checks = 0, errs = 0;
  logic [9:0] eq [4];
  bit         cq [4];
  string      tq [4];

  always #5 clk = ~clk;

  trs_regen #(
    .SPL_A(SPLA), .LINES_A(LNA), .ACT_A(ACA), .VB_A(VBA),
    .SPL_B(SPLB), .LINES_B(LNB), .ACT_B(ACB), .VB_B(VBB)
  ) u0 (
    .clk(clk), .rst(rst), .din(din), .std_code(std_code), .fw_en(fw_en),
    .ins_en(ins_en), .blk_en(blk_en), .dout(dout)
  );

  function automatic logic [9:0] bxyz(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  task automatic drive(input logic [9:0] w, input logic [9:0] e, input bit c, input string t);
    @(negedge clk);
    if (cq[3]) begin
      checks++;
      if (dout !== eq[3]) begin
        errs++;
        $display("FAIL %s: dout=%h expected=%h", t == "" ? tq[3] : tq[3], dout, eq[3]);
      end
    end
    for (int i = 3; i > 0; i--) begin eq[i] = eq[i-1]; cq[i] = cq[i-1]; tq[i] = tq[i-1]; end
    eq[0] = e; cq[0] = c; tq[0] = t;
    din = w;
  endtask

  // sb: 0 = standard A, 1 = standard B
  task automatic run_lines(input bit sb, input int first, input int n, input bit loss,
                           input bit corrupt, input bit mis, input bit chk,
                           input bit lockexp, input string tag);
    int spl, lns, vb, savp, half;
    spl  = sb ? SPLB : SPLA;
    lns  = sb ? LNB : LNA;
    vb   = sb ? VBB : VBA;
    savp = spl - (sb ? ACB : ACA) - 4;
    half = lns / 2;
    for (int k = 0; k < n; k++) begin
      int ln;
      bit f, v;
      ln = (first + k) % lns;
      f  = ln >= half;
      v  = (ln < vb) || (f && ln < half + vb);
      for (int hh = 0; hh < spl; hh++) begin
        logic [9:0] w, e, g;
        string t;
        bit win, ism;
        int ix;
        win = (hh < 4) || (hh >= savp && hh < savp + 4);
        ix  = (hh < 4) ? hh : hh - savp;
        ism = mis && !loss && (ln % 2 == 1) && hh >= savp + 4 && hh < savp + 8;
        g = (ix == 0) ? 10'h3FF : (ix == 3) ? bxyz(f, v, hh < 4) : 10'h000;
        if (loss)                         w = 10'h040;
        else if (win && ix == 3 && corrupt) w = g ^ 10'h03C;
        else if (win)                     w = g;
        else if (ism) begin
          int j;
          j = hh - savp - 4;
          w = (j == 0) ? 10'h3FF : (j == 3) ? bxyz(f, v, 1'b0) : 10'h000;
        end else                          w = 10'(256 + hh * 7 + ln);
        if (lockexp && ins_en && win) begin
          e = g; t = (ix == 3) ? "R2,R5,R11" : "R4";
        end else if (lockexp && blk_en && ism) begin
          e = (hh % 2 == 1) ? 10'h040 : 10'h200; t = "R6";
        end else begin
          e = w; t = tag;
        end
        drive(w, e, chk, t);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin eq[i] = '0; cq[i] = 1'b0; tq[i] = ""; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (dout !== 10'h000) begin errs++; $display("FAIL R1: dout=%h expected=%h after reset", dout, 10'h000); end

    // R1: pure delay, flywheel locks and line-syncs meanwhile
    std_code = 2'b01; fw_en = 1'b1;
    run_lines(1'b0, 0, 3 * LNA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R1");
    // R4 R5 R6 R2 R11: both edits enabled, damaged ID words and misplaced sequences
    ins_en = 1'b1; blk_en = 1'b1;
    run_lines(1'b0, 0, 2 * LNA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R1");
    // insert only: misplaced sequences pass through
    blk_en = 1'b0;
    run_lines(1'b0, 0, LNA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
    // R7: blank only, well-placed damaged sequences untouched
    ins_en = 1'b0; blk_en = 1'b1;
    run_lines(1'b0, 0, LNA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    // R8: signal and standard code lost, insertion continues
    ins_en = 1'b1; std_code = 2'b00;
    run_lines(1'b0, 0, 2 * LNA, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    // R9: flywheel disabled
    fw_en = 1'b0; std_code = 2'b01;
    run_lines(1'b0, 0, LNA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    // R3: re-enabled but no sync sequences in the input
    fw_en = 1'b1;
    run_lines(1'b0, 0, 2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
    // R10: switch to standard B, first line before lock is untouched
    std_code = 2'b10;
    run_lines(1'b1, 0, 1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
    run_lines(1'b1, 1, LNB - 1 + LNB, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
    run_lines(1'b1, 0, LNB, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
    for (int i = 0; i < 5; i++) drive(10'h040, 10'h040, 1'b0, "");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule